// File: doc/BRIEF.md
# Interrupt Request and Service Tracker

This block tracks eight interrupt request lines for an interrupt controller. Each line is captured into a pending-request register. A configuration input picks how capture works: in edge mode a rising edge on a line is latched, and in level mode the register follows the line. A fixed-priority resolver compares the pending requests with an in-service register. Line 0 has the highest priority. The resolver raises a request to the processor only when some pending line outranks every line already in service.

The processor answers with two active-low acknowledge pulses. The block synchronizes the acknowledge input and then acts on three events:

- **First falling edge.** The pending register is frozen and the winning line is moved into service.
- **Second pulse.** The 3-bit number of the served line is presented.
- **Final rising edge.** The handshake ends. If automatic end-of-interrupt is enabled, the served line's in-service bit is cleared here.

Otherwise the bit stays set until a non-specific end-of-interrupt command pulse arrives. That command releases the highest-priority line in service.

Request and acknowledge inputs each pass a two-flop synchronizer. A change on them becomes visible at the outputs a few clocks later. The trigger mode and the auto-clear selection are expected to be static between resets.

Top module: `irq_tracker`

## Requirements
- R1: After reset `irq_o` and `vec_valid_o` are 0, `vec_o` is 0 and no line is pending or in service.
- R2: With `level_mode_i`=0, a 0-to-1 transition on `ir_i[n]` makes line n pending. A line that stays high after being served does not request again.
- R3: With `level_mode_i`=1, the pending bit n follows `ir_i[n]`. A line dropped before the first acknowledge falling edge is not served, and that handshake returns vector 7.
- R4: Priority is fixed with line 0 highest. The served line is the lowest-numbered pending line that outranks all in-service lines.
- R5: On the first acknowledge falling edge the winner's in-service bit is set and the pending register is frozen for the rest of the handshake. In edge mode the winner's pending bit is cleared.
- R6: `irq_o` is 1 only while no handshake is in progress and some pending line n has no in-service bit at index n or below.
- R7: During the second acknowledge low pulse `vec_valid_o`=1 and `vec_o` holds the served line number in binary. If nothing was eligible at the first falling edge, `vec_o`=7 and no in-service bit is set. Outside that pulse `vec_valid_o`=0 and `vec_o`=0.
- R8: With `auto_eoi_i`=1 the served in-service bit clears on the final acknowledge rising edge.
- R9: With `auto_eoi_i`=0 an in-service bit clears only on a one-cycle `eoi_i` pulse. Each pulse clears only the lowest-numbered set bit.
- R10: In edge mode a rising edge that arrives during a handshake is kept and becomes pending once the handshake ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_mode_i | input | 1 | 1: level capture, 0: rising-edge capture |
| auto_eoi_i | input | 1 | 1: clear in-service bit at end of handshake |
| ir_i | input | 8 | Interrupt request lines, bit n is line n |
| inta_ni | input | 1 | Acknowledge from processor, active low |
| eoi_i | input | 1 | Non-specific end-of-interrupt command pulse |
| irq_o | output | 1 | Interrupt request to processor |
| vec_o | output | 3 | Number of the line being served |
| vec_valid_o | output | 1 | High while `vec_o` is presented |

## Verification
The in-code assertions cover several rules on every cycle:
- the pending register stays still while frozen;
- at most one in-service bit appears per acknowledge, and only on the first falling edge;
- without auto-clear, an in-service bit drops only after a command pulse;
- the vector is stable while presented and follows the correct pulse order.

Other behaviour only the bench scenarios can show:
- which line wins under mixed pending and in-service sets;
- edge versus level capture, including withdrawal before acknowledge;
- edges held across a handshake;
- nested service released by commands.

These are checked against a reference model in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned VEC_W   = $clog2(NUM_IRQ);
  localparam int unsigned SYNC_N  = 2;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_P1   = 2'd1,
    ACK_GAP  = 2'd2,
    ACK_P2   = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               level_mode_i,
  input  logic [NUM_IRQ-1:0] ir_sync_i,
  input  logic               freeze_i,
  input  logic [NUM_IRQ-1:0] take_i,
  output logic [NUM_IRQ-1:0] irr_o
);
  logic [NUM_IRQ-1:0] ir_prev_q, hold_q, irr_q, rise;

  assign rise = ir_sync_i & ~ir_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_prev_q <= '0;
    else         ir_prev_q <= ir_sync_i;
  end

  // edges seen while frozen are parked and merged after the handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      hold_q <= '0;
    end else if (level_mode_i) begin
      hold_q <= '0;
      if (!freeze_i) irr_q <= ir_sync_i;
    end else if (freeze_i) begin
      irr_q  <= irr_q & ~take_i;
      hold_q <= hold_q | rise;
    end else begin
      irr_q  <= (irr_q | rise | hold_q) & ~take_i;
      hold_q <= '0;
    end
  end

  assign irr_o = irr_q;

  AST_FROZEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i && $past(freeze_i) |-> $stable(irr_q)); // R5
  AST_LEVEL_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i && $past(level_mode_i) |-> hold_q == '0); // R3
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
(
  input  logic [NUM_IRQ-1:0] irr_i,
  input  logic [NUM_IRQ-1:0] isr_i,
  output logic               win_valid_o,
  output logic [VEC_W-1:0]   win_idx_o,
  output logic [NUM_IRQ-1:0] win_onehot_o,
  output logic [NUM_IRQ-1:0] isr_top_o
);
  logic [NUM_IRQ-1:0] allowed, eligible;

  // line n may interrupt only if no line 0..n is in service
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_allow
    assign allowed[i] = ~(|isr_i[i:0]);
  end

  assign eligible    = irr_i & allowed;
  assign win_valid_o = |eligible;

  always_comb begin
    win_idx_o = '0;
    for (int i = NUM_IRQ-1; i >= 0; i--) begin
      if (eligible[i]) win_idx_o = VEC_W'(i);
    end
  end

  assign win_onehot_o = eligible & (~eligible + 1'b1);
  assign isr_top_o    = isr_i & (~isr_i + 1'b1);

  AST_WIN_ONEHOT: assert final ($onehot0(win_onehot_o)); // R4
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inta_sync_i,
  output ack_state_e state_o,
  output logic       first_fall_o,
  output logic       last_rise_o
);
  ack_state_e state_q, state_d;
  logic prev_q, fall, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= inta_sync_i;
  end

  assign fall = prev_q & ~inta_sync_i;
  assign rise = ~prev_q & inta_sync_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE: if (fall) state_d = ACK_P1;
      ACK_P1:   if (rise) state_d = ACK_GAP;
      ACK_GAP:  if (fall) state_d = ACK_P2;
      ACK_P2:   if (rise) state_d = ACK_IDLE;
      default:  state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ACK_IDLE;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign first_fall_o = (state_q == ACK_IDLE) && fall;
  assign last_rise_o  = (state_q == ACK_P2) && rise;

  AST_P2_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ACK_P2 |-> $past(state_q) == ACK_P2 || $past(state_q) == ACK_GAP); // R7
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               level_mode_i,
  input  logic               auto_eoi_i,
  input  logic [NUM_IRQ-1:0] ir_i,
  input  logic               inta_ni,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  logic [NUM_IRQ-1:0] ir_sync, irr, isr_q, isr_d, take, served_q;
  logic [NUM_IRQ-1:0] win_onehot, isr_top;
  logic [VEC_W-1:0]   win_idx, vec_q;
  logic               win_valid, inta_sync, first_fall, last_rise;
  ack_state_e         ack_state;

  irq_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_N), .RST_VAL(1'b0)) i_ir_sync (
    .clk_i, .rst_ni, .d_i(ir_i), .q_o(ir_sync)
  );

  irq_sync #(.WIDTH(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) i_ack_sync (
    .clk_i, .rst_ni, .d_i(inta_ni), .q_o(inta_sync)
  );

  irq_ack_seq i_ack_seq (
    .clk_i, .rst_ni, .inta_sync_i(inta_sync), .state_o(ack_state),
    .first_fall_o(first_fall), .last_rise_o(last_rise)
  );

  assign take = (first_fall && !level_mode_i) ? win_onehot : '0;

  irq_capture i_capture (
    .clk_i, .rst_ni, .level_mode_i, .ir_sync_i(ir_sync),
    .freeze_i(ack_state != ACK_IDLE), .take_i(take), .irr_o(irr)
  );

  irq_resolve i_resolve (
    .irr_i(irr), .isr_i(isr_q), .win_valid_o(win_valid), .win_idx_o(win_idx),
    .win_onehot_o(win_onehot), .isr_top_o(isr_top)
  );

  always_comb begin
    isr_d = isr_q;
    if (first_fall && win_valid)  isr_d = isr_d | win_onehot;
    if (eoi_i)                    isr_d = isr_d & ~isr_top;
    if (last_rise && auto_eoi_i)  isr_d = isr_d & ~served_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      served_q <= '0;
      vec_q    <= '0;
    end else begin
      isr_q <= isr_d;
      if (first_fall) begin
        served_q <= win_valid ? win_onehot : '0;
        vec_q    <= win_valid ? win_idx : '1;
      end
    end
  end

  assign irq_o       = (ack_state == ACK_IDLE) && win_valid;
  assign vec_valid_o = (ack_state == ACK_P2);
  assign vec_o       = vec_valid_o ? vec_q : '0;

  AST_ONE_SET_PER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q & ~$past(isr_q)) <= 1); // R5
  AST_SET_ON_FIRST_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(isr_q & ~$past(isr_q)) |-> $past(first_fall)); // R5
  AST_MANUAL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_eoi_i && |($past(isr_q) & ~isr_q) |-> $past(eoi_i)); // R9
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && $past(vec_valid_o) |-> $stable(vec_o)); // R7
  AST_NO_IRQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !irq_o); // R6
endmodule

// File: tb/test_irq_tracker.sv
module test_irq_tracker;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       level_mode, auto_eoi, inta_n = 1'b1, eoi = 1'b0;
  logic [7:0] ir = '0;
  logic       irq;
  logic [2:0] vec;
  logic       vec_valid;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_irr, m_isr;

  always #4 clk = ~clk;

  irq_tracker i_irq_tracker (
    .clk_i(clk), .rst_ni, .level_mode_i(level_mode), .auto_eoi_i(auto_eoi),
    .ir_i(ir), .inta_ni(inta_n), .eoi_i(eoi),
    .irq_o(irq), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_win();
    for (int i = 0; i < 8; i++)
      if (m_irr[i] && ((m_isr & ((9'd2 << i) - 9'd1)) == 0)) return i;
    return -1;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_irq(input string tag);
    chk(irq, (m_win() >= 0) ? 1 : 0, tag);
  endtask

  task automatic do_reset(input logic lvl, input logic aut);
    rst_ni = 1'b0; ir = '0; inta_n = 1'b1; eoi = 1'b0;
    level_mode = lvl; auto_eoi = aut;
    m_irr = '0; m_isr = '0;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    chk(irq, 0, "R1 irq after reset");
    chk(vec_valid, 0, "R1 vec_valid after reset");
    chk(vec, 0, "R1 vec after reset");
  endtask

  task automatic set_ir(input logic [7:0] v, input string tag);
    if (level_mode) m_irr = v;
    else            m_irr = m_irr | (v & ~ir);
    ir = v;
    wait_n(6);
    check_irq(tag);
  endtask

  task automatic pulse_eoi();
    logic [7:0] top;
    eoi = 1'b1; wait_n(1); eoi = 1'b0;
    top = m_isr & (~m_isr + 8'd1);
    m_isr = m_isr & ~top;
    wait_n(4);
    check_irq("R9 irq after eoi");
  endtask

  task automatic handshake(input logic [7:0] mid_rise);
    int w;
    logic [7:0] pend;
    pend = '0;
    w = m_win();
    inta_n = 1'b0; wait_n(5);
    chk(irq, 0, "R6 irq low during handshake");
    chk(vec_valid, 0, "R7 no vector in first pulse");
    if (w >= 0) begin
      m_isr[w] = 1'b1;
      if (!level_mode) m_irr[w] = 1'b0;
    end
    inta_n = 1'b1; wait_n(3);
    if (mid_rise != 0) begin
      pend = mid_rise & ~ir;
      ir = ir | mid_rise;
    end
    wait_n(3);
    inta_n = 1'b0; wait_n(5);
    chk(vec_valid, 1, "R7 vec_valid in second pulse");
    chk(vec, (w >= 0) ? w : 7, "R4 served vector");
    inta_n = 1'b1; wait_n(5);
    chk(vec_valid, 0, "R7 vec_valid after handshake");
    if (w >= 0 && auto_eoi) m_isr[w] = 1'b0;
    if (level_mode) m_irr = ir;
    else            m_irr = m_irr | pend;
    check_irq("R8 R10 irq after handshake");
  endtask

  task automatic random_ops(input int n);
    for (int k = 0; k < n; k++) begin
      case ($urandom % 3)
        0: set_ir(8'($urandom), "R2 R3 R6 random request");
        1: handshake('0);
        default: pulse_eoi();
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));

    // edge mode, auto clear
    do_reset(1'b0, 1'b1);
    set_ir(8'h28, "R2 edge request");
    handshake('0);                       // R4: line 3 before line 5
    handshake('0);                       // line 5
    chk(irq, 0, "R2 held line no re-request");
    set_ir(8'h00, "R2 drop lines");
    set_ir(8'h04, "R2 new edge");
    handshake(8'h10);                    // R10: line 4 edge mid-handshake
    chk(irq, 1, "R10 held edge pending");
    handshake('0);
    random_ops(40);

    // level mode, auto clear
    do_reset(1'b1, 1'b1);
    set_ir(8'h08, "R3 level request");
    set_ir(8'h00, "R3 level withdrawn");
    handshake('0);                       // R3: vector 7, nothing served
    set_ir(8'h41, "R3 two levels");
    handshake('0);
    random_ops(40);

    // edge mode, manual clear
    do_reset(1'b0, 1'b0);
    set_ir(8'h20, "R9 request line 5");
    handshake('0);
    set_ir(8'h22, "R9 request line 1");
    handshake('0);
    set_ir(8'h62, "R9 line 6 behind line 5");
    pulse_eoi();                         // R9: clears line 1 only
    chk(irq, 0, "R9 line 5 still blocks line 6");
    pulse_eoi();
    chk(irq, 1, "R9 line 6 released");
    random_ops(40);

    // level mode, manual clear
    do_reset(1'b1, 1'b0);
    random_ops(40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule